// File: doc/BRIEF.md
# Serial Delta-RGB Pixel Serializer

This block turns a stream of 24-bit RGB pixels into a narrow 8-bit panel bus. Each accepted pixel is sent as three consecutive 8-bit beats, one beat per dot clock. Because one pixel uses three ticks, any horizontal timing counted in pixels must be multiplied by three before it is applied on the dot-clock side.

The order in which the three colour components go out can differ between odd and even display lines. Two 3-bit permutation codes in a configuration word control this, one for odd lines and one for even lines. Delta-type panels use RGB on odd lines and GBR on even lines. Plain serial panels use RGB on every line.

Line parity comes from the start-of-line and start-of-frame markers that travel with the pixels. The configuration word is captured once per frame, on the pixel that carries start-of-frame.

Top module: `delta_rgb_serializer`

## Requirements
- R1: An accepted pixel is driven out over the next three cycles as beats 0, 1 and 2, with `dot_de` high on each of them. The first beat appears in the cycle after acceptance.
- R2: `pix_ready` is high whenever no pixel is being sent, and also on the cycle of the third beat. It is low on the first and second beats. A continuous stream is therefore accepted at most once every three cycles, with no idle beat between pixels.
- R3: The odd-line code is `order_cfg[6:4]` and the even-line code is `order_cfg[2:0]`. Bits 3 and 7 have no effect.
- R4: Codes list the components in transmit order: 0=R,G,B; 1=R,B,G; 2=G,R,B; 3=G,B,R; 4=B,R,G; 5=B,G,R. R is `pix_rgb[23:16]`, G is `pix_rgb[15:8]` and B is `pix_rgb[7:0]`.
- R5: Codes 6 and 7 send the components in R,G,B order.
- R6: A pixel with `pix_sof` high is on line 1, which is odd, and also starts a line. Each later pixel with `pix_sol` high and `pix_sof` low flips the parity. Other pixels keep the parity of the previous pixel.
- R7: `order_cfg` is sampled only when a `pix_sof` pixel is accepted, and that pixel already uses the new value. Changes at any other time have no effect until the next frame.
- R8: While no pixel is being sent, `dot_de` is low and `dot_data` is zero.
- R9: `dot_sol` and `dot_sof` are high only on beat 0 of a pixel that carried the matching marker.
- R10: A synchronous active-high `rst` clears the beat state, leaves `dot_de` low with `dot_data` zero and `pix_ready` high, and returns the parity to odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Pixel offered |
| pix_ready | output | 1 | Pixel may be taken this cycle |
| pix_rgb | input | 24 | Pixel: R [23:16], G [15:8], B [7:0] |
| pix_sol | input | 1 | Pixel is the first of a line |
| pix_sof | input | 1 | Pixel is the first of a frame |
| order_cfg | input | 8 | Odd-line code [6:4], even-line code [2:0] |
| dot_data | output | 8 | Panel data beat |
| dot_de | output | 1 | Beat carries pixel data |
| dot_sol | output | 1 | First beat of a line |
| dot_sof | output | 1 | First beat of a frame |

## Verification
The bench sweeps all 64 pairs of odd-line and even-line codes. For each pair it sends a three-line frame that has distinct bit patterns in R, G and B, so any wrong permutation or wrong parity shows up as a different byte. Lines 1 and 3 against line 2 distinguish a parity that toggles from one that is stuck or inverted. The spare bits 3 and 7 are set differently across the sweep, and `order_cfg` is flipped right after each start-of-frame pixel, so a design that reads those bits or re-samples mid-frame produces miscompares. Back-to-back pixels test that the handshake gives exactly one ready cycle per three beats, and the idle gaps between frames test that the bus is quiet.

// File: rtl/rgbs_pkg.sv
package rgbs_pkg;
    localparam int NCOMP  = 3;
    localparam int SEL_W  = 2;
    localparam int CODE_W = 3;

    typedef logic [SEL_W-1:0] csel_t;

    localparam csel_t CSEL_R = 2'd0;
    localparam csel_t CSEL_G = 2'd1;
    localparam csel_t CSEL_B = 2'd2;

    typedef enum logic [CODE_W-1:0] {
        ORD_RGB = 3'd0,
        ORD_RBG = 3'd1,
        ORD_GRB = 3'd2,
        ORD_GBR = 3'd3,
        ORD_BRG = 3'd4,
        ORD_BGR = 3'd5
    } order_e;
endpackage

// File: rtl/rgbs_order_decode.sv
module rgbs_order_decode
    import rgbs_pkg::*;
(
    input  logic [CODE_W-1:0]           code,
    output logic [NCOMP-1:0][SEL_W-1:0] order_sel
);
    always_comb begin
        order_sel[0] = CSEL_R;
        order_sel[1] = CSEL_G;
        order_sel[2] = CSEL_B;
        case (code)
            ORD_RBG: begin order_sel[0] = CSEL_R; order_sel[1] = CSEL_B; order_sel[2] = CSEL_G; end
            ORD_GRB: begin order_sel[0] = CSEL_G; order_sel[1] = CSEL_R; order_sel[2] = CSEL_B; end
            ORD_GBR: begin order_sel[0] = CSEL_G; order_sel[1] = CSEL_B; order_sel[2] = CSEL_R; end
            ORD_BRG: begin order_sel[0] = CSEL_B; order_sel[1] = CSEL_R; order_sel[2] = CSEL_G; end
            ORD_BGR: begin order_sel[0] = CSEL_B; order_sel[1] = CSEL_G; order_sel[2] = CSEL_R; end
            default: begin order_sel[0] = CSEL_R; order_sel[1] = CSEL_G; order_sel[2] = CSEL_B; end // R5: reserved codes
        endcase
    end
endmodule

// File: rtl/rgbs_line_track.sv
module rgbs_line_track
    import rgbs_pkg::*;
#(
    parameter int CFG_W    = 8,
    parameter int ODD_LSB  = 4,
    parameter int EVEN_LSB = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              take_sol,
    input  logic              take_sof,
    input  logic [CFG_W-1:0]  cfg,
    output logic [CODE_W-1:0] code
);
    typedef struct packed {
        logic              even;
        logic [CODE_W-1:0] odd_code;
        logic [CODE_W-1:0] even_code;
    } lt_state_t;

    lt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            if (take_sof) begin
                st_d.even      = 1'b0;
                st_d.odd_code  = cfg[ODD_LSB +: CODE_W];
                st_d.even_code = cfg[EVEN_LSB +: CODE_W];
            end else if (take_sol) begin
                st_d.even = ~st_q.even;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign code = st_q.even ? st_q.even_code : st_q.odd_code;

    assert_sof_odd_R6: assert property (@(posedge clk) disable iff (rst)
        (take && take_sof) |=> !st_q.even);
    assert_sol_flip_R6: assert property (@(posedge clk) disable iff (rst)
        (take && take_sol && !take_sof) |=> (st_q.even != $past(st_q.even)));
    assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        !(take && take_sof) |=> ($stable(st_q.odd_code) && $stable(st_q.even_code)));
endmodule

// File: rtl/rgbs_beat_seq.sv
module rgbs_beat_seq
    import rgbs_pkg::*;
#(
    parameter int COMP_W = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic [COMP_W*NCOMP-1:0]      in_data,
    input  logic                         in_sol,
    input  logic                         in_sof,
    input  logic [NCOMP-1:0][SEL_W-1:0]  order_sel,
    output logic                         in_ready,
    output logic                         take,
    output logic [COMP_W-1:0]            out_data,
    output logic                         out_de,
    output logic                         out_sol,
    output logic                         out_sof
);
    localparam int PIX_W  = COMP_W * NCOMP;
    localparam int BEAT_W = $clog2(NCOMP);
    localparam logic [BEAT_W-1:0] LAST = BEAT_W'(NCOMP - 1);

    typedef struct packed {
        logic              active;
        logic [BEAT_W-1:0] beat;
        logic [PIX_W-1:0]  pix;
        logic              sol;
        logic              sof;
    } bs_state_t;

    bs_state_t st_d, st_q;
    logic [COMP_W-1:0] comp [NCOMP];
    logic [SEL_W-1:0]  cur_sel;

    for (genvar k = 0; k < NCOMP; k++) begin : g_comp
        assign comp[k] = st_q.pix[PIX_W-1-k*COMP_W -: COMP_W];
    end

    assign in_ready = !st_q.active || (st_q.beat == LAST);
    assign take     = in_valid && in_ready;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.active = 1'b1;
            st_d.beat   = '0;
            st_d.pix    = in_data;
            st_d.sol    = in_sol;
            st_d.sof    = in_sof;
        end else if (st_q.active) begin
            if (st_q.beat == LAST) begin
                st_d.active = 1'b0;
                st_d.beat   = '0;
            end else begin
                st_d.beat = st_q.beat + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        cur_sel  = order_sel[st_q.beat];
        out_data = '0;
        if (st_q.active) begin
            for (int k = 0; k < NCOMP; k++) begin
                if (cur_sel == SEL_W'(k)) out_data = comp[k];
            end
        end
    end

    assign out_de  = st_q.active;
    assign out_sol = st_q.active && (st_q.beat == '0) && st_q.sol;
    assign out_sof = st_q.active && (st_q.beat == '0) && st_q.sof;

    assert_accept_first_beat_R1: assert property (@(posedge clk) disable iff (rst)
        take |=> (out_de && st_q.beat == '0));
    assert_beat_advance_R1: assert property (@(posedge clk) disable iff (rst)
        (st_q.active && st_q.beat != LAST) |=> (out_de && st_q.beat == BEAT_W'($past(st_q.beat) + 1'b1)));
    assert_ready_gap_R2: assert property (@(posedge clk) disable iff (rst)
        take |=> !in_ready);
    assert_quiet_after_last_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q.active && st_q.beat == LAST && !in_valid) |=> (!out_de && out_data == '0));
endmodule

// File: rtl/delta_rgb_serializer.sv
module delta_rgb_serializer
    import rgbs_pkg::*;
#(
    parameter int COMP_W   = 8,
    parameter int CFG_W    = 8,
    parameter int ODD_LSB  = 4,
    parameter int EVEN_LSB = 0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pix_valid,
    output logic                    pix_ready,
    input  logic [COMP_W*NCOMP-1:0] pix_rgb,
    input  logic                    pix_sol,
    input  logic                    pix_sof,
    input  logic [CFG_W-1:0]        order_cfg,
    output logic [COMP_W-1:0]       dot_data,
    output logic                    dot_de,
    output logic                    dot_sol,
    output logic                    dot_sof
);
    logic                        take;
    logic [CODE_W-1:0]           code;
    logic [NCOMP-1:0][SEL_W-1:0] order_sel;

    rgbs_line_track #(
        .CFG_W(CFG_W), .ODD_LSB(ODD_LSB), .EVEN_LSB(EVEN_LSB)
    ) u_line (
        .clk(clk), .rst(rst), .take(take), .take_sol(pix_sol),
        .take_sof(pix_sof), .cfg(order_cfg), .code(code)
    );

    rgbs_order_decode u_dec (
        .code(code), .order_sel(order_sel)
    );

    rgbs_beat_seq #(.COMP_W(COMP_W)) u_seq (
        .clk(clk), .rst(rst), .in_valid(pix_valid), .in_data(pix_rgb),
        .in_sol(pix_sol), .in_sof(pix_sof), .order_sel(order_sel),
        .in_ready(pix_ready), .take(take), .out_data(dot_data),
        .out_de(dot_de), .out_sol(dot_sol), .out_sof(dot_sof)
    );

    assert_marker_needs_de_R9: assert property (@(posedge clk) disable iff (rst)
        (dot_sol || dot_sof) |-> (dot_de && $past(pix_valid && pix_ready)));
endmodule

// File: tb/tb_delta_rgb_serializer.sv
`timescale 1ns/1ps
module tb_delta_rgb_serializer;
    logic        clk = 1'b0;
    logic        rst;
    logic        pix_valid;
    logic        pix_ready;
    logic [23:0] pix_rgb;
    logic        pix_sol;
    logic        pix_sof;
    logic [7:0]  order_cfg;
    logic [7:0]  dot_data;
    logic        dot_de;
    logic        dot_sol;
    logic        dot_sof;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    delta_rgb_serializer dut (
        .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_ready(pix_ready),
        .pix_rgb(pix_rgb), .pix_sol(pix_sol), .pix_sof(pix_sof),
        .order_cfg(order_cfg), .dot_data(dot_data), .dot_de(dot_de),
        .dot_sol(dot_sol), .dot_sof(dot_sof)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Component index (0=R,1=G,2=B) sent at a beat, derived arithmetically from the code.
    function automatic int exp_idx(input int code, input int beat);
        int c, first, lo, hi;
        c     = (code > 5) ? 0 : code;
        first = c / 2;
        lo    = (first == 0) ? 1 : 0;
        hi    = (first == 2) ? 1 : 2;
        if (beat == 0)      return first;
        else if (beat == 1) return (c % 2 == 0) ? lo : hi;
        else                return (c % 2 == 0) ? hi : lo;
    endfunction

    // Called just after a falling edge; returns just after the falling edge of the third beat.
    task automatic send(input logic [23:0] px, input bit sol, input bit sof, input int code);
        pix_valid = 1'b1; pix_rgb = px; pix_sol = sol; pix_sof = sof;
        check(pix_ready == 1'b1, "R2 ready before accept", 32'(pix_ready), 1);
        @(posedge clk); @(negedge clk);
        pix_valid = 1'b0; pix_sol = 1'b0; pix_sof = 1'b0;
        for (int b = 0; b < 3; b++) begin
            logic [7:0] e;
            if (b > 0) begin @(posedge clk); @(negedge clk); end
            e = px[23 - 8*exp_idx(code, b) -: 8];
            check(dot_de == 1'b1, "R1 beat enable", 32'(dot_de), 1);
            // Data check also covers R1 (beat order), R3 (field), R6 (parity), R7 (frame capture)
            check(dot_data == e, (code > 5) ? "R5 reserved order (R1 R3 R6 R7)" : "R4 order (R1 R3 R6 R7)",
                  32'(dot_data), 32'(e));
            check(dot_sol == (b == 0 && sol), "R9 line marker", 32'(dot_sol), 32'(b == 0 && sol));
            check(dot_sof == (b == 0 && sof), "R9 frame marker", 32'(dot_sof), 32'(b == 0 && sof));
            check(pix_ready == (b == 2), "R2 ready spacing", 32'(pix_ready), 32'(b == 2));
        end
    endtask

    initial begin
        rst = 1'b1; pix_valid = 1'b0; pix_rgb = '0; pix_sol = 1'b0; pix_sof = 1'b0; order_cfg = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(dot_de == 1'b0, "R10 reset enable", 32'(dot_de), 0);
        check(dot_data == 8'h00, "R10 reset data", 32'(dot_data), 0);
        check(pix_ready == 1'b1, "R10 reset ready", 32'(pix_ready), 1);
        rst = 1'b0;
        for (int o = 0; o < 8; o++) begin
            for (int e = 0; e < 8; e++) begin
                logic [7:0] cfg;
                cfg = {1'(e), 3'(o), 1'(o + 1), 3'(e)};
                order_cfg = cfg;
                for (int line = 1; line <= 3; line++) begin
                    for (int p = 0; p < 2; p++) begin
                        logic [23:0] px;
                        px = {2'b00, 3'(o), 3'(e),
                              2'b01, 2'(line), 1'(p), 3'(o),
                              2'b11, 3'(e), 1'b0, 2'(line)};
                        send(px, p == 0, (line == 1 && p == 0), (line % 2 == 1) ? o : e);
                        if (line == 1 && p == 0) order_cfg = ~cfg; // R7: mid-frame change ignored
                    end
                end
                @(posedge clk); @(negedge clk);
                check(dot_de == 1'b0, "R8 idle enable", 32'(dot_de), 0);
                check(dot_data == 8'h00, "R8 idle data", 32'(dot_data), 0);
                check(pix_ready == 1'b1, "R2 idle ready", 32'(pix_ready), 1);
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL R1 watchdog: actual %0h expected %0h", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule